// File: doc/BRIEF.md
# Counted Sample Writer with Register Port

This peripheral takes packed 32-bit sample words from an ADC capture driver and stores them in system memory on its own. Software programs a sample count and a destination address through a small register port, then sets a start bit. Each accepted sample goes into a 16-entry queue. A write-only master port drains the queue one word at a time and waits while the memory raises wait-request. Successive words go to addresses four bytes apart, or all to one address when fixed mode is selected.

Three sticky status flags report progress and faults: done, queue overflow, and a read of an unmapped offset. A self-clearing control bit performs a soft reset of the engine. A separate register holds a word meant for the capture driver, and bit 0 of that word sets the driver's read-mode line (1 = single line, 0 = two lines). The word reaches the driver only when software asks for it through the control register.

Top module: `acq_dma_ctrl`

## Requirements
- R1: Register offsets are: 0 control, 1 sample count, 2 base address, 3 status, 4 driver word. Offsets 1, 2 and 4 read back the last value written. Offsets 5 to 7 read as zero.
- R2: A read of offset 5, 6 or 7 sets status bit 2. The bit stays set until a soft reset.
- R3: Writing control with bit 0 set starts a run. The run writes exactly `count` words, in arrival order, to base, base+4, base+8, and so on.
- R4: When bit 2 is also set in the start write, every write of that run uses the base address.
- R5: While `m_write` is high and `m_waitreq` is high, `m_write`, `m_addr` and `m_wdata` hold their values. A word is transferred on a cycle with `m_write` high and `m_waitreq` low.
- R6: `m_byteen` is 4'b1111 whenever `m_write` is high.
- R7: Status bit 0 (done) sets after the count-th transfer. A new start clears it. A start with count 0 sets it at once and produces no write.
- R8: The queue holds 16 words. A sample that arrives during a run while the queue is full is dropped and sets sticky status bit 1.
- R9: Writing control with bit 1 set performs a soft reset one cycle later. The soft reset stops the run, empties the queue, clears all status bits, and leaves control bit 1 reading 0.
- R10: `drv_mode` takes bit 0 of the driver word only when control is written with bit 3 set. Writing the driver word alone does not change `drv_mode`.
- R11: Samples that arrive while no run is active are ignored and never written.
- R12: After reset, status reads 0, control reads 0, `m_write` is low and `drv_mode` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_addr | input | 3 | Register offset |
| s_write | input | 1 | Register write strobe |
| s_read | input | 1 | Register read strobe |
| s_wdata | input | 32 | Register write data |
| s_rdata | output | 32 | Register read data (combinational) |
| m_addr | output | 32 | Memory write address |
| m_write | output | 1 | Memory write request |
| m_byteen | output | 4 | Byte enables |
| m_wdata | output | 32 | Memory write data |
| m_waitreq | input | 1 | Memory stall |
| smp_data | input | 32 | Packed sample from the capture driver |
| smp_valid | input | 1 | Sample strobe |
| drv_mode | output | 1 | Read-mode select to the capture driver |

## Verification
The bench holds wait-request high while more than sixteen samples arrive. A design that queued too deep, or kept the newest words instead of the oldest, would store the wrong words or leave the overflow flag clear. Random stalls during runs expose a master that moves its address or data before the handshake completes, or that counts a stalled cycle as a transfer; either fault gives missing or shifted words. Fixed mode, count zero, a start that should clear done, idle samples, and a soft reset issued in the middle of a run each catch a different error: an address that advances when it should not, an early or late done, or stale queue contents written out later.

// File: rtl/acq_dma_ctrl.sv
module acq_dma_ctrl #(
  parameter int FIFO_DEPTH = 16,
  parameter int AW         = 32,
  parameter int ADDR_STEP  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    s_addr,
  input  logic          s_write,
  input  logic          s_read,
  input  logic [31:0]   s_wdata,
  output logic [31:0]   s_rdata,
  output logic [AW-1:0] m_addr,
  output logic          m_write,
  output logic [3:0]    m_byteen,
  output logic [31:0]   m_wdata,
  input  logic          m_waitreq,
  input  logic [31:0]   smp_data,
  input  logic          smp_valid,
  output logic          drv_mode
);

  localparam int PTR_W = $clog2(FIFO_DEPTH);

  logic [3:0]    ctrl_q;
  logic [31:0]   cnt_q, base_q, drvw_q, left_q;
  logic          done_q, ovf_q, bad_q, active_q, fixed_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   mem [FIFO_DEPTH];
  logic [PTR_W:0] wp_q, rp_q;

  wire [PTR_W:0] occ   = wp_q - rp_q;
  wire           full  = (occ == (PTR_W+1)'(FIFO_DEPTH));
  wire           empty = (occ == '0);
  wire           ctrl_wr = s_write && (s_addr == 3'd0);
  wire           sreset  = ctrl_q[1];
  wire           start   = ctrl_wr && s_wdata[0] && !sreset;
  wire           push    = smp_valid && active_q && !full && !sreset && !start;
  wire           fire    = m_write && !m_waitreq;

  assign m_write  = active_q && !empty;
  assign m_addr   = addr_q;
  assign m_wdata  = mem[rp_q[PTR_W-1:0]];
  assign m_byteen = 4'hF;

  always_comb begin
    case (s_addr)
      3'd0:    s_rdata = {28'd0, ctrl_q};
      3'd1:    s_rdata = cnt_q;
      3'd2:    s_rdata = base_q;
      3'd3:    s_rdata = {29'd0, bad_q, ovf_q, done_q};
      3'd4:    s_rdata = drvw_q;
      default: s_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; cnt_q <= '0; base_q <= '0; drvw_q <= '0;
      drv_mode <= 1'b0; bad_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      if (s_write && s_addr == 3'd1) cnt_q  <= s_wdata;
      if (s_write && s_addr == 3'd2) base_q <= s_wdata;
      if (s_write && s_addr == 3'd4) drvw_q <= s_wdata;
      if (sreset)      ctrl_q <= ctrl_q & 4'b0100;
      else if (ctrl_wr) ctrl_q <= s_wdata[3:0];
      if (ctrl_wr && s_wdata[3] && !sreset) drv_mode <= drvw_q[0];
      if (sreset) bad_q <= 1'b0;
      else if (s_read && s_addr > 3'd4) bad_q <= 1'b1;
      if (sreset) ovf_q <= 1'b0;
      else if (smp_valid && active_q && full) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0; done_q <= 1'b0; fixed_q <= 1'b0;
      left_q <= '0; addr_q <= '0; wp_q <= '0; rp_q <= '0;
    end else if (sreset) begin
      active_q <= 1'b0; done_q <= 1'b0; wp_q <= '0; rp_q <= '0;
    end else if (start) begin
      fixed_q  <= s_wdata[2];
      addr_q   <= base_q[AW-1:0];
      left_q   <= cnt_q;
      wp_q     <= '0;
      rp_q     <= '0;
      active_q <= (cnt_q != 32'd0);
      done_q   <= (cnt_q == 32'd0);
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (fire) begin
        rp_q   <= rp_q + 1'b1;
        left_q <= left_q - 32'd1;
        if (!fixed_q) addr_q <= addr_q + AW'(ADDR_STEP);
        if (left_q == 32'd1) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q[PTR_W-1:0]] <= smp_data;
  end

  p_hold_while_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_write && m_waitreq && !sreset && !start |=> m_write && $stable(m_addr) && $stable(m_wdata));

  p_step_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !fixed_q && !sreset && !start |=> m_addr == $past(m_addr) + AW'(ADDR_STEP));

  p_fixed_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && fixed_q && !sreset && !start |=> $stable(m_addr));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !m_write);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !sreset |=> ovf_q);

  p_fifo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (PTR_W+1)'(FIFO_DEPTH));

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> !m_write && !done_q && !ovf_q && !bad_q && !ctrl_q[1]);

endmodule

// File: tb/tb_acq_dma_ctrl.sv
module tb_acq_dma_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] s_addr = '0;
  logic s_write = 0, s_read = 0, m_waitreq = 0, smp_valid = 0;
  logic [31:0] s_wdata = '0, smp_data = '0, s_rdata, m_wdata;
  logic [31:0] m_addr;
  logic m_write, drv_mode;
  logic [3:0] m_byteen;

  acq_dma_ctrl dut (.clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_write(s_write),
    .s_read(s_read), .s_wdata(s_wdata), .s_rdata(s_rdata), .m_addr(m_addr),
    .m_write(m_write), .m_byteen(m_byteen), .m_wdata(m_wdata), .m_waitreq(m_waitreq),
    .smp_data(smp_data), .smp_valid(smp_valid), .drv_mode(drv_mode));

  int errs = 0, checks = 0, wmode = 0;
  int cap_n = 0, hold_bad = 0, be_bad = 0;
  logic [31:0] cap_a [64];
  logic [31:0] cap_d [64];
  logic prev_stall = 0;
  logic [31:0] prev_a = '0, prev_d = '0;

  always @(negedge clk)
    m_waitreq <= (wmode == 1) ? 1'b1 : (wmode == 2) ? 1'b0 : 1'($urandom_range(0, 1));

  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_stall && !(m_write && m_addr == prev_a && m_wdata == prev_d)) hold_bad++;
      if (m_write && m_byteen != 4'hF) be_bad++;
      if (m_write && !m_waitreq) begin
        if (cap_n < 64) begin cap_a[cap_n] = m_addr; cap_d[cap_n] = m_wdata; end
        cap_n++;
      end
      prev_stall = m_write && m_waitreq;
      prev_a = m_addr; prev_d = m_wdata;
    end
  end

  function automatic logic [31:0] sval(int run, int i);
    return (32'(run) << 24) ^ (32'(i) * 32'h0001_0203) ^ 32'h5A00_0000;
  endfunction

  function automatic logic [31:0] exp_addr(logic [31:0] base, int i, bit fixed);
    return fixed ? base : base + 32'(4 * i);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); s_addr = a; s_wdata = d; s_write = 1;
    @(negedge clk); s_write = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); s_addr = a; s_read = 1; #1 d = s_rdata;
    @(negedge clk); s_read = 0;
  endtask

  task automatic push(int run, int n, int gmin, int gmax);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_data = sval(run, i); smp_valid = 1;
      @(negedge clk); smp_valid = 0;
      repeat ($urandom_range(gmin, gmax)) @(negedge clk);
    end
  endtask

  task automatic wait_done(output logic ok);
    logic [31:0] st;
    ok = 0;
    for (int k = 0; k < 500 && !ok; k++) begin rd(3'd3, st); ok = st[0]; end
  endtask

  task automatic run_check(string req, int run, int n, logic [31:0] base, bit fixed);
    chk(req, "write count", 32'(cap_n), 32'(n));
    for (int i = 0; i < n && i < 64; i++) begin
      chk(req, "address", cap_a[i], exp_addr(base, i, fixed));
      chk(req, "data", cap_d[i], sval(run, i));
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    logic ok;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12 reset state
    rd(3'd3, v); chk("R12", "status", v, 0);
    rd(3'd0, v); chk("R12", "control", v, 0);
    chk("R12", "m_write", 32'(m_write), 0);
    chk("R12", "drv_mode", 32'(drv_mode), 0);

    // R1 readback, R2 unmapped read
    wr(3'd1, 32'hDEAD_0012); wr(3'd2, 32'h0000_4440); wr(3'd4, 32'hCAFE_0001);
    rd(3'd1, v); chk("R1", "count", v, 32'hDEAD_0012);
    rd(3'd2, v); chk("R1", "base", v, 32'h0000_4440);
    rd(3'd4, v); chk("R1", "driver word", v, 32'hCAFE_0001);
    rd(3'd3, v); chk("R2", "status before bad read", v, 0);
    rd(3'd6, v); chk("R1", "unmapped offset reads zero", v, 0);
    rd(3'd3, v); chk("R2", "status after bad read", v, 32'h4);
    rd(3'd4, v); rd(3'd3, v); chk("R2", "flag sticky", v, 32'h4);

    // R10 driver mode
    chk("R10", "drv_mode after word write only", 32'(drv_mode), 0);
    wr(3'd0, 32'h8); @(negedge clk);
    chk("R10", "drv_mode after transfer", 32'(drv_mode), 1);
    wr(3'd4, 32'h0); @(negedge clk);
    chk("R10", "drv_mode holds until transfer", 32'(drv_mode), 1);
    wr(3'd0, 32'h8); @(negedge clk);
    chk("R10", "drv_mode cleared by transfer", 32'(drv_mode), 0);

    // R9 soft reset clears the unmapped-read flag
    wr(3'd0, 32'h2); @(negedge clk);
    rd(3'd3, v); chk("R9", "status after soft reset", v, 0);
    rd(3'd0, v); chk("R9", "control bit1 self-clear", v & 32'h2, 0);

    // R11 idle samples ignored
    cap_n = 0;
    push(9, 3, 1, 2); repeat (10) @(negedge clk);
    chk("R11", "idle writes", 32'(cap_n), 0);

    // R3 incrementing run, random stalls (R5, R6)
    wmode = 0; cap_n = 0;
    wr(3'd1, 32'd12); wr(3'd2, 32'h0000_1000); wr(3'd0, 32'h1);
    push(1, 12, 2, 5); wait_done(ok);
    chk("R7", "done after incrementing run", 32'(ok), 1);
    run_check("R3", 1, 12, 32'h0000_1000, 0);

    // R7 new start clears done; R4 fixed run
    cap_n = 0;
    wr(3'd1, 32'd9); wr(3'd2, 32'h0000_2000); wr(3'd0, 32'h5);
    rd(3'd3, v); chk("R7", "done cleared by start", v & 32'h1, 0);
    push(2, 9, 2, 5); wait_done(ok);
    chk("R7", "done after fixed run", 32'(ok), 1);
    run_check("R4", 2, 9, 32'h0000_2000, 1);

    // R7 zero count
    cap_n = 0;
    wr(3'd1, 32'd0); wr(3'd0, 32'h1);
    rd(3'd3, v); chk("R7", "zero count done", v & 32'h1, 1);
    push(3, 2, 1, 1); repeat (6) @(negedge clk);
    chk("R7", "zero count writes", 32'(cap_n), 0);

    // R8 overflow with stalled memory
    wmode = 1; cap_n = 0;
    wr(3'd1, 32'd40); wr(3'd2, 32'h0000_3000); wr(3'd0, 32'h1);
    push(4, 20, 0, 0);
    rd(3'd3, v); chk("R8", "status overflow", v, 32'h2);
    chk("R5", "write held under stall", 32'(m_write), 1);
    chk("R5", "no transfer under stall", 32'(cap_n), 0);
    wmode = 2; repeat (40) @(negedge clk);
    run_check("R8", 4, 16, 32'h0000_3000, 0);
    rd(3'd3, v); chk("R8", "overflow sticky, not done", v, 32'h2);

    // R9 soft reset mid-run
    wr(3'd0, 32'h2); @(negedge clk);
    rd(3'd3, v); chk("R9", "status cleared", v, 0);
    rd(3'd0, v); chk("R9", "control bit1", v & 32'h2, 0);
    push(5, 2, 1, 1); repeat (6) @(negedge clk);
    chk("R9", "engine stopped", 32'(cap_n), 16);
    chk("R9", "m_write low", 32'(m_write), 0);

    chk("R5", "stall hold violations", 32'(hold_bad), 0);
    chk("R6", "byte enable violations", 32'(be_bad), 0);
    finish_up();
  end
endmodule